// File: doc/BRIEF.md
# Memory-to-Memory Vector Multiply Coprocessor

This coprocessor takes one command, multiplies two vectors of signed 16-bit elements element by element, and writes the 32-bit signed products back to main memory. It works only on memory addresses. A command names where the first source vector starts, where the second source vector starts and where the result goes, and it gives the element count as an immediate. The host hands the command over with a valid/ready handshake and may carry on with independent work while the block runs.

Each command runs through a fixed sequence of phases. The decode phase clamps the length and latches the addresses. The inbound phase uses the built-in DMA engine to copy both source vectors from main memory into private local storage. The compute phase is a pipelined multiplier that reads and writes only the local storage. A result-decode phase follows. In the outbound phase the DMA engine copies the products to the destination. Because every command pays this fixed setup, short vectors cost relatively more, and long vectors amortise it.

The main-memory port is one word wide and uses a request/grant scheme. It issues at most one transfer per granted cycle and has a fixed read latency of one cycle.

Top module: `vmul_copro`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err` and `mem_req` are 0 and `cmd_ready` is 1. While not busy, no memory request is made.
- R2: For a length L between 1 and 64, each destination word `dst+i` (i < L) receives the 32-bit signed product of the low 16 bits of word `src1+i` and the low 16 bits of word `src2+i`. The upper 16 bits of source words are ignored. No other word is written.
- R3: All reads of a command take place before its first write to main memory.
- R4: A command of length L makes exactly 2L reads, all inside the two source ranges, and exactly L writes, all inside the destination range.
- R5: `done` is a single-cycle pulse. It follows the last result write, and `busy` is 0 while `done` is 1.
- R6: From accept until `done`, `cmd_ready` is 0. A command held valid during that time is accepted afterwards and executed correctly.
- R7: A length of zero makes no memory traffic and raises `done` in the second cycle after accept.
- R8: A length above 64 is processed as length 64 and sets `err`. `err` stays 1 until the next command is accepted, and a command of legal length clears it.
- R9: A request that is not granted stays asserted in the next cycle with the same address and direction.
- R10: With grant held high, each extra element adds exactly 4 cycles to the time from accept to `done`: two reads, one compute issue and one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_src1 | input | AW | First source start word address |
| cmd_src2 | input | AW | Second source start word address |
| cmd_dst | input | AW | Destination start word address |
| cmd_len | input | LW | Element count (immediate) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command's length was clamped |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 2*EW | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 2*EW | Read data, one cycle after a granted read |

## Verification
Lengths 1 to 16 are swept twice. The first sweep holds grant high, so the cycle-exact latency slope can be measured. The second uses a pseudo-random grant, which exposes hold and ordering errors that a stall-free port would hide. Each element pattern includes the most negative and most positive 16-bit values, so sign handling and product width are exercised. Source words carry junk in their upper halves to show that only the low half is used. Zero, 64, 65 and 200 separate the empty path, the full buffer and the clamp. A command held during a busy run, and a guard word just past each destination, show that nothing is dropped and nothing stray is written.

// File: rtl/vmul_copro.sv
module vmul_copro #(
  parameter int AW     = 16,
  parameter int EW     = 16,
  parameter int LW     = 8,
  parameter int MAXLEN = 64,
  parameter int LAT    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_src1,
  input  logic [AW-1:0]   cmd_src2,
  input  logic [AW-1:0]   cmd_dst,
  input  logic [LW-1:0]   cmd_len,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [2*EW-1:0] mem_wdata,
  input  logic            mem_gnt,
  input  logic [2*EW-1:0] mem_rdata
);
  localparam int IW = $clog2(MAXLEN);
  localparam int NW = IW + 1;
  localparam int CW = IW + 2;
  localparam int WW = 2 * EW;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_LOAD, S_COMP, S_RDEC, S_STORE, S_DONE
  } state_t;

  state_t st;
  logic [AW-1:0] s1_q, s2_q, d_q;
  logic [LW-1:0] len_q;
  logic [NW-1:0] n_q;
  logic [CW-1:0] cnt, rd_slot;
  logic          rd_pend, err_q;

  logic signed [EW-1:0] la [MAXLEN];
  logic signed [EW-1:0] lb [MAXLEN];
  logic        [WW-1:0] lr [MAXLEN];

  logic          p_v [LAT];
  logic [IW-1:0] p_i [LAT];
  logic [WW-1:0] p_d [LAT];

  logic [CW-1:0] n_c, n2;
  logic          accept, ld_req, st_req, cp_iss, pipe_busy;
  logic signed [WW-1:0] prod;

  assign n_c       = CW'(n_q);
  assign n2        = {n_q, 1'b0};
  assign cmd_ready = (st == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);
  assign err       = err_q;

  assign ld_req  = (st == S_LOAD) && (cnt < n2);
  assign st_req  = (st == S_STORE) && (cnt < n_c);
  assign mem_req = ld_req || st_req;
  assign mem_we  = (st == S_STORE);
  assign mem_addr = (st == S_STORE) ? d_q + AW'(cnt)
                  : (cnt < n_c)     ? s1_q + AW'(cnt)
                  :                   s2_q + AW'(cnt - n_c);
  assign mem_wdata = lr[cnt[IW-1:0]];

  assign cp_iss = (st == S_COMP) && (cnt < n_c);
  assign prod   = la[cnt[IW-1:0]] * lb[cnt[IW-1:0]];

  always_comb begin
    pipe_busy = 1'b0;
    for (int k = 0; k < LAT; k++) pipe_busy = pipe_busy | p_v[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      s1_q    <= '0;
      s2_q    <= '0;
      d_q     <= '0;
      len_q   <= '0;
      n_q     <= '0;
      cnt     <= '0;
      rd_slot <= '0;
      rd_pend <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rd_pend <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          s1_q  <= cmd_src1;
          s2_q  <= cmd_src2;
          d_q   <= cmd_dst;
          len_q <= cmd_len;
          err_q <= 1'b0;
          st    <= S_DEC;
        end
        S_DEC: begin
          cnt <= '0;
          if (len_q > LW'(MAXLEN)) begin
            n_q   <= NW'(MAXLEN);
            err_q <= 1'b1;
          end else begin
            n_q <= NW'(len_q);
          end
          st <= (len_q == '0) ? S_DONE : S_LOAD;
        end
        S_LOAD: begin
          if (ld_req && mem_gnt) begin
            rd_pend <= 1'b1;
            rd_slot <= cnt;
            cnt     <= cnt + 1'b1;
          end else if (!ld_req && !rd_pend) begin
            cnt <= '0;
            st  <= S_COMP;
          end
        end
        S_COMP: begin
          if (cp_iss) cnt <= cnt + 1'b1;
          else if (!pipe_busy) begin
            cnt <= '0;
            st  <= S_RDEC;
          end
        end
        S_RDEC: st <= S_STORE;
        S_STORE: if (st_req && mem_gnt) begin
          cnt <= cnt + 1'b1;
          if (cnt == n_c - 1'b1) st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) begin
        p_v[k] <= 1'b0;
        p_i[k] <= '0;
        p_d[k] <= '0;
      end
    end else begin
      p_v[0] <= cp_iss;
      p_i[0] <= cnt[IW-1:0];
      p_d[0] <= prod;
      for (int k = 1; k < LAT; k++) begin
        p_v[k] <= p_v[k-1];
        p_i[k] <= p_i[k-1];
        p_d[k] <= p_d[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_pend) begin
      if (rd_slot < n_c) la[rd_slot[IW-1:0]] <= mem_rdata[EW-1:0];
      else               lb[IW'(rd_slot - n_c)] <= mem_rdata[EW-1:0];
    end
    if (p_v[LAT-1]) lr[p_i[LAT-1]] <= p_d[LAT-1];
  end
endmodule

// File: rtl/vmul_copro_chk.sv
module vmul_copro_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr
);
  logic wrote;

  always_ff @(posedge clk) begin
    if (!rst_n) wrote <= 1'b0;
    else if (cmd_valid && cmd_ready) wrote <= 1'b0;
    else if (mem_req && mem_gnt && mem_we) wrote <= 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  assert_reads_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrote && mem_req) |-> mem_we);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind vmul_copro vmul_copro_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_addr(mem_addr)
);

// File: tb/tb_vmul_copro.sv
module tb_vmul_copro;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_src1 = '0, cmd_src2 = '0, cmd_dst = '0;
  logic [7:0]  cmd_len = '0;
  logic busy, done, err, mem_req, mem_we, mem_gnt;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  vmul_copro dut (.*);

  logic [31:0] mem [0:1023];
  logic [7:0]  lfsr = 8'h5a;
  bit   gnt_full = 1'b1, chk_rng = 1'b1;
  int   cur_id = 0, wr_id = -1, rd_n = 0, wr_n = 0, bad_n = 0;
  int   s1 = 100, s2 = 300, d = 600, le = 0;
  int   tests = 0, fails = 0;
  int   lat_tab [0:16];

  assign mem_gnt = gnt_full ? 1'b1 : (lfsr[1:0] != 2'b00);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_req && mem_gnt) begin
      int a;
      a = int'(mem_addr);
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_n++;
        wr_id <= cur_id;
        if (chk_rng && !(a >= d && a < d + le)) bad_n++;
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
        rd_n++;
        if (wr_id == cur_id) bad_n++;
        if (chk_rng && !((a >= s1 && a < s1 + le) || (a >= s2 && a < s2 + le))) bad_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] aval(int i, int seed);
    if (i == 0) return 16'h8000;
    if (i == 1) return 16'h7fff;
    return 16'(i * 7919 + seed * 131 - 20000);
  endfunction

  function automatic logic [15:0] bval(int i, int seed);
    if (i < 2) return 16'h8000;
    if (i == 2) return 16'h7fff;
    return 16'((i * 4099) ^ (seed * 37));
  endfunction

  task automatic fill(int a1, int a2, int ad, int seed);
    for (int i = 0; i < 70; i++) begin
      mem[a1 + i] = {16'hdead ^ 16'(i), aval(i, seed)};
      mem[a2 + i] = {16'hbeef ^ 16'(i), bval(i, seed)};
      mem[ad + i] = 32'ha5a5_0000 | i;
    end
  endtask

  task automatic check_res(int ad, int a1, int a2, int n);
    for (int i = 0; i < n; i++) begin
      logic signed [31:0] e;
      e = $signed(mem[a1 + i][15:0]) * $signed(mem[a2 + i][15:0]);
      check(mem[ad + i] == e, "R2 product", mem[ad + i], e);
    end
    check(mem[ad + n] == (32'ha5a5_0000 | n), "R2 guard", mem[ad + n], 32'ha5a5_0000 | n);
  endtask

  task automatic issue(int a1, int a2, int ad, int len);
    @(negedge clk);
    cmd_src1 = 16'(a1); cmd_src2 = 16'(a2); cmd_dst = 16'(ad); cmd_len = 8'(len);
    cmd_valid = 1'b1;
    for (int k = 0; k < 5000 && !cmd_ready; k++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run(int len, bit full, int seed, output int lat);
    int rd0, wr0, bad0;
    gnt_full = full; chk_rng = 1'b1;
    le = (len > 64) ? 64 : len;
    fill(s1, s2, d, seed);
    cur_id++;
    rd0 = rd_n; wr0 = wr_n; bad0 = bad_n;
    issue(s1, s2, d, len);
    lat = 1;
    while (!done && lat < 6000) begin
      @(negedge clk);
      lat++;
    end
    check(done, "R5 done seen", done, 1);
    check(!busy, "R5 busy low at done", busy, 0);
    check_res(d, s1, s2, le);
    check(rd_n - rd0 == 2 * le, "R4 read count", rd_n - rd0, 2 * le);
    check(wr_n - wr0 == le, "R4 write count", wr_n - wr0, le);
    check(bad_n == bad0, "R3 R4 order and range", bad_n - bad0, 0);
    check(err == (len > 64), "R8 err flag", err, len > 64);
    @(negedge clk);
    check(!done, "R5 done one cycle", done, 0);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !mem_req && cmd_ready, "R1 reset state",
          {busy, done, err, mem_req, cmd_ready}, 5'b00001);

    run(0, 1'b1, 1, lat);
    check(lat == 2, "R7 zero length latency", lat, 2);
    lat_tab[0] = lat;

    for (int l = 1; l <= 16; l++) begin
      run(l, 1'b1, l, lat);
      lat_tab[l] = lat;
      if (l >= 2)
        check(lat_tab[l] - lat_tab[l-1] == 4, "R10 per-element cost", lat_tab[l] - lat_tab[l-1], 4);
    end
    check(lat_tab[1] > lat_tab[0], "R10 setup overhead", lat_tab[1], lat_tab[0] + 1);

    for (int l = 1; l <= 16; l++) run(l, 1'b0, l + 40, lat);

    run(64, 1'b1, 7, lat);
    run(64, 1'b0, 8, lat);
    run(65, 1'b1, 9, lat);
    run(200, 1'b0, 10, lat);
    run(3, 1'b0, 11, lat);

    begin
      int rd0, wr0, hold_bad = 0, k = 0;
      chk_rng = 1'b0; gnt_full = 1'b0;
      fill(100, 300, 600, 21);
      fill(200, 450, 800, 22);
      cur_id++;
      rd0 = rd_n; wr0 = wr_n;
      issue(100, 300, 600, 8);
      cmd_src1 = 16'd200; cmd_src2 = 16'd450; cmd_dst = 16'd800; cmd_len = 8'd5;
      cmd_valid = 1'b1;
      while (!done && k < 5000) begin
        if (cmd_ready) hold_bad++;
        @(negedge clk);
        k++;
      end
      check(hold_bad == 0, "R6 ready low while busy", hold_bad, 0);
      for (int j = 0; j < 5000 && !cmd_ready; j++) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      cur_id++;
      for (int j = 0; j < 5000 && !done; j++) @(negedge clk);
      check(done, "R6 held command completes", done, 1);
      check_res(600, 100, 300, 8);
      check_res(800, 200, 450, 5);
      check(rd_n - rd0 == 26 && wr_n - wr0 == 13, "R6 traffic of both commands",
            (rd_n - rd0) + (wr_n - wr0), 39);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule